// File: doc/BRIEF.md
# Multi-Buffer DMA Channel Sequencer

This block decides, for each channel of a DMA controller, what happens when a buffer transfer has finished writing its last data to the destination. At every buffer boundary it looks at the channel's mode row and picks one of three outcomes. The first is reloading the source and destination addresses and repeating the buffer, for automatic reload. The second is fetching the next descriptor through a pointer, for a linked list. The third is terminating the channel, because the buffer just completed was the last one. The move engine, the bus master and descriptor reads are outside the block. A one-cycle request leaves the block, and a load-done handshake comes back. With that handshake a fetched descriptor's fetch-disable bits and next pointer arrive on a shared load bus.

Each channel keeps two status bits. The buffer-complete bit is set at every buffer end. The chain-complete bit is set when the channel terminates. Both bits are sticky and are set whatever the masks hold. Each bit drives an interrupt line through its own mask. All channels are independent copies, and their number and the pointer width are parameters.

Top module: `mbseq_top`

## Requirements
- R1: A `ch_en` pulse on an idle channel makes `xfer_en` high on the next cycle. It also captures the channel's fetch-disable bits and pointer from the config inputs. `ch_en` has no effect on a channel that is not idle.
- R2: A buffer end (a `buf_done` pulse while `xfer_en` is high) may find the row in a stop state. Here a stop row is one that is neither the reload row of R3 nor the fetch row of R5, for example `cfg_auto`=0 with both fetch-disable bits at 1. In that case `ch_done` pulses for exactly one cycle, on the cycle after the buffer end. `xfer_en` falls in the same cycle, and no request is raised.
- R3: A buffer end with `cfg_auto`=1, both working fetch-disable bits at 1 and at least one reload bit at 1 raises `req_reload` for one cycle. `xfer_en` stays low until a `ld_done` pulse, and is high again on the cycle after it.
- R4: `cfg_auto` is sampled at each buffer end. After any number of reloads, clearing it during a buffer makes that buffer's end terminate the channel.
- R5: A buffer end with either working fetch-disable bit at 0 and a non-zero working pointer raises `req_fetch` for one cycle. `req_ptr` then shows that pointer. The matching `ld_done` loads `ld_src_nofetch`, `ld_dst_nofetch` and `ld_ptr` into the channel's working state.
- R6: A loaded descriptor with both fetch-disable bits at 1 and pointer 0 makes the following buffer end terminate the channel, which ends the chain.
- R7: `st_buf` is set on the cycle after every buffer end, whatever the mask holds. A `buf_done` on a channel whose `xfer_en` is low has no effect.
- R8: `st_chain` is set in the same cycle as `ch_done`, whatever the mask holds.
- R9: Both status bits are sticky until a one-cycle clear strobe. A set and a clear in the same cycle leave the bit at 1.
- R10: `irq_buf` equals `st_buf` AND `msk_buf`, and `irq_chain` equals `st_chain` AND `msk_chain`, bit by bit per channel.
- R11: Channels are independent. Activity on one channel leaves the outputs of the others unchanged.
- R12: A `ld_done` on a channel that is not waiting for a load has no effect on its working pointer, which is visible on `req_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Channel start pulse |
| cfg_src_rel | input | NCH | Source address reload enable |
| cfg_dst_rel | input | NCH | Destination address reload enable |
| cfg_src_nofetch | input | NCH | Source descriptor fetch disabled |
| cfg_dst_nofetch | input | NCH | Destination descriptor fetch disabled |
| cfg_auto | input | NCH | Automatic mode, sampled at each buffer end |
| cfg_ptr | input | NCH*PW | Initial next-descriptor pointer per channel |
| buf_done | input | NCH | Last data of a buffer written to destination |
| ld_done | input | NCH | Reload or descriptor load finished |
| ld_src_nofetch | input | 1 | Loaded descriptor source fetch-disable bit |
| ld_dst_nofetch | input | 1 | Loaded descriptor destination fetch-disable bit |
| ld_ptr | input | PW | Loaded descriptor next pointer |
| xfer_en | output | NCH | Transfer enabled for the channel |
| req_reload | output | NCH | One-cycle address reload request |
| req_fetch | output | NCH | One-cycle descriptor fetch request |
| req_ptr | output | NCH*PW | Working pointer per channel |
| ch_done | output | NCH | One-cycle termination pulse |
| msk_buf | input | NCH | Buffer-complete interrupt mask |
| msk_chain | input | NCH | Chain-complete interrupt mask |
| st_clr_buf | input | NCH | Buffer-complete status clear |
| st_clr_chain | input | NCH | Chain-complete status clear |
| st_buf | output | NCH | Buffer-complete status |
| st_chain | output | NCH | Chain-complete status |
| irq_buf | output | NCH | Buffer-complete interrupt |
| irq_chain | output | NCH | Chain-complete interrupt |

## Verification
A wrong row decision shows on the very next cycle. The wrong one of `req_reload`, `req_fetch` or `ch_done` pulses, and `xfer_en` takes the wrong level. A stale or corrupted working pointer or fetch-disable bit stays hidden until the next buffer end. At that point it shows as a wrong `req_ptr` or as a chain that stops too early or runs on. For that reason the bench always follows a load with one more buffer end. The sweep covers every combination of mode bits and a zero and a non-zero pointer. Each case is followed to termination, so a broken status or mask path appears within a few cycles of the buffer end.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;

  typedef enum logic [1:0] {
    CH_IDLE    = 2'd0,
    CH_RUN     = 2'd1,
    CH_WAIT_RL = 2'd2,
    CH_WAIT_FT = 2'd3
  } ch_state_e;

  typedef enum logic [1:0] {
    ACT_STOP   = 2'd0,
    ACT_RELOAD = 2'd1,
    ACT_FETCH  = 2'd2
  } bend_act_e;

endpackage

// File: rtl/mbseq_row_decode.sv
module mbseq_row_decode
  import mbseq_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          auto_i,
  input  logic          src_rel_i,
  input  logic          dst_rel_i,
  input  logic          src_nf_i,
  input  logic          dst_nf_i,
  input  logic [PW-1:0] ptr_i,
  output bend_act_e     act_o
);

  logic reload_row;
  logic fetch_row;

  assign reload_row = auto_i && src_nf_i && dst_nf_i && (src_rel_i || dst_rel_i);
  assign fetch_row  = (!src_nf_i || !dst_nf_i) && (ptr_i != '0);

  always_comb begin
    if (reload_row) begin
      act_o = ACT_RELOAD;
    end else if (fetch_row) begin
      act_o = ACT_FETCH;
    end else begin
      act_o = ACT_STOP;
    end
  end

endmodule

// File: rtl/mbseq_chan_fsm.sv
module mbseq_chan_fsm
  import mbseq_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          buf_done_i,
  input  logic          ld_done_i,
  input  logic          cfg_src_rel_i,
  input  logic          cfg_dst_rel_i,
  input  logic          cfg_src_nf_i,
  input  logic          cfg_dst_nf_i,
  input  logic          cfg_auto_i,
  input  logic [PW-1:0] cfg_ptr_i,
  input  logic          ld_src_nf_i,
  input  logic          ld_dst_nf_i,
  input  logic [PW-1:0] ld_ptr_i,
  output logic          xfer_en_o,
  output logic          req_reload_o,
  output logic          req_fetch_o,
  output logic [PW-1:0] req_ptr_o,
  output logic          done_o,
  output logic          bend_o,
  output logic          last_o
);

  ch_state_e     st_q, st_d;
  logic          sf_q, sf_d;
  logic          df_q, df_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          desc_en;
  logic          rl_q, rl_d;
  logic          ft_q, ft_d;
  logic          dn_q, dn_d;
  bend_act_e     act;
  logic          bend;

  mbseq_row_decode #(.PW(PW)) u_dec (
    .auto_i    (cfg_auto_i),
    .src_rel_i (cfg_src_rel_i),
    .dst_rel_i (cfg_dst_rel_i),
    .src_nf_i  (sf_q),
    .dst_nf_i  (df_q),
    .ptr_i     (ptr_q),
    .act_o     (act)
  );

  assign bend = (st_q == CH_RUN) && buf_done_i;

  // next-state process
  always_comb begin
    st_d    = st_q;
    sf_d    = sf_q;
    df_d    = df_q;
    ptr_d   = ptr_q;
    desc_en = 1'b0;
    rl_d    = 1'b0;
    ft_d    = 1'b0;
    dn_d    = 1'b0;
    case (st_q)
      CH_IDLE: begin
        if (en_i) begin
          st_d    = CH_RUN;
          sf_d    = cfg_src_nf_i;
          df_d    = cfg_dst_nf_i;
          ptr_d   = cfg_ptr_i;
          desc_en = 1'b1;
        end
      end
      CH_RUN: begin
        if (buf_done_i) begin
          case (act)
            ACT_RELOAD: begin
              st_d = CH_WAIT_RL;
              rl_d = 1'b1;
            end
            ACT_FETCH: begin
              st_d = CH_WAIT_FT;
              ft_d = 1'b1;
            end
            default: begin
              st_d = CH_IDLE;
              dn_d = 1'b1;
            end
          endcase
        end
      end
      CH_WAIT_RL: begin
        if (ld_done_i) begin
          st_d = CH_RUN;
        end
      end
      CH_WAIT_FT: begin
        if (ld_done_i) begin
          st_d    = CH_RUN;
          sf_d    = ld_src_nf_i;
          df_d    = ld_dst_nf_i;
          ptr_d   = ld_ptr_i;
          desc_en = 1'b1;
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  // state and pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CH_IDLE;
      rl_q <= 1'b0;
      ft_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rl_q <= rl_d;
      ft_q <= ft_d;
      dn_q <= dn_d;
    end
  end

  // working descriptor registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q  <= 1'b1;
      df_q  <= 1'b1;
      ptr_q <= '0;
    end else if (desc_en) begin
      sf_q  <= sf_d;
      df_q  <= df_d;
      ptr_q <= ptr_d;
    end
  end

  assign xfer_en_o    = (st_q == CH_RUN);
  assign req_reload_o = rl_q;
  assign req_fetch_o  = ft_q;
  assign req_ptr_o    = ptr_q;
  assign done_o       = dn_q;
  assign bend_o       = bend;
  assign last_o       = bend && (act == ACT_STOP);

endmodule

// File: rtl/mbseq_status.sv
module mbseq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_buf_i,
  input  logic set_chain_i,
  input  logic clr_buf_i,
  input  logic clr_chain_i,
  input  logic msk_buf_i,
  input  logic msk_chain_i,
  output logic st_buf_o,
  output logic st_chain_o,
  output logic irq_buf_o,
  output logic irq_chain_o
);

  logic buf_q, buf_d;
  logic chn_q, chn_d;

  always_comb begin
    buf_d = buf_q;
    if (clr_buf_i) buf_d = 1'b0;
    if (set_buf_i) buf_d = 1'b1;
    chn_d = chn_q;
    if (clr_chain_i) chn_d = 1'b0;
    if (set_chain_i) chn_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= 1'b0;
      chn_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      chn_q <= chn_d;
    end
  end

  assign st_buf_o    = buf_q;
  assign st_chain_o  = chn_q;
  assign irq_buf_o   = buf_q & msk_buf_i;
  assign irq_chain_o = chn_q & msk_chain_i;

endmodule

// File: rtl/mbseq_top.sv
module mbseq_top #(
  parameter int NCH = 4,
  parameter int PW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ch_en,
  input  logic [NCH-1:0]  cfg_src_rel,
  input  logic [NCH-1:0]  cfg_dst_rel,
  input  logic [NCH-1:0]  cfg_src_nofetch,
  input  logic [NCH-1:0]  cfg_dst_nofetch,
  input  logic [NCH-1:0]  cfg_auto,
  input  logic [NCH*PW-1:0] cfg_ptr,
  input  logic [NCH-1:0]  buf_done,
  input  logic [NCH-1:0]  ld_done,
  input  logic            ld_src_nofetch,
  input  logic            ld_dst_nofetch,
  input  logic [PW-1:0]   ld_ptr,
  output logic [NCH-1:0]  xfer_en,
  output logic [NCH-1:0]  req_reload,
  output logic [NCH-1:0]  req_fetch,
  output logic [NCH*PW-1:0] req_ptr,
  output logic [NCH-1:0]  ch_done,
  input  logic [NCH-1:0]  msk_buf,
  input  logic [NCH-1:0]  msk_chain,
  input  logic [NCH-1:0]  st_clr_buf,
  input  logic [NCH-1:0]  st_clr_chain,
  output logic [NCH-1:0]  st_buf,
  output logic [NCH-1:0]  st_chain,
  output logic [NCH-1:0]  irq_buf,
  output logic [NCH-1:0]  irq_chain
);

  localparam int PTRW = NCH * PW;

  logic [NCH-1:0] bend;
  logic [NCH-1:0] last;
  logic [PTRW-1:0] ptr_all;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mbseq_chan_fsm #(.PW(PW)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (ch_en[c]),
      .buf_done_i    (buf_done[c]),
      .ld_done_i     (ld_done[c]),
      .cfg_src_rel_i (cfg_src_rel[c]),
      .cfg_dst_rel_i (cfg_dst_rel[c]),
      .cfg_src_nf_i  (cfg_src_nofetch[c]),
      .cfg_dst_nf_i  (cfg_dst_nofetch[c]),
      .cfg_auto_i    (cfg_auto[c]),
      .cfg_ptr_i     (cfg_ptr[c*PW +: PW]),
      .ld_src_nf_i   (ld_src_nofetch),
      .ld_dst_nf_i   (ld_dst_nofetch),
      .ld_ptr_i      (ld_ptr),
      .xfer_en_o     (xfer_en[c]),
      .req_reload_o  (req_reload[c]),
      .req_fetch_o   (req_fetch[c]),
      .req_ptr_o     (ptr_all[c*PW +: PW]),
      .done_o        (ch_done[c]),
      .bend_o        (bend[c]),
      .last_o        (last[c])
    );

    mbseq_status u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_buf_i   (bend[c]),
      .set_chain_i (last[c]),
      .clr_buf_i   (st_clr_buf[c]),
      .clr_chain_i (st_clr_chain[c]),
      .msk_buf_i   (msk_buf[c]),
      .msk_chain_i (msk_chain[c]),
      .st_buf_o    (st_buf[c]),
      .st_chain_o  (st_chain[c]),
      .irq_buf_o   (irq_buf[c]),
      .irq_chain_o (irq_chain[c])
    );
  end

  assign req_ptr = ptr_all;

endmodule

// File: rtl/mbseq_chk.sv
module mbseq_chk #(
  parameter int NCH = 4,
  parameter int PW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    buf_done,
  input logic [NCH-1:0]    xfer_en,
  input logic [NCH-1:0]    req_reload,
  input logic [NCH-1:0]    req_fetch,
  input logic [NCH*PW-1:0] req_ptr,
  input logic [NCH-1:0]    ch_done,
  input logic [NCH-1:0]    st_buf,
  input logic [NCH-1:0]    st_chain
);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_reload[i], req_fetch[i], ch_done[i]})); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[i] |-> !xfer_en[i]); // R2

    AST_REQ_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_reload[i] || req_fetch[i]) |-> !xfer_en[i]); // R3

    AST_FETCH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      req_fetch[i] |-> (req_ptr[i*PW +: PW] != '0)); // R5

    AST_BUF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_buf[i]) |-> $past(buf_done[i])); // R7

    AST_CHAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[i] |-> st_chain[i]); // R8
  end

endmodule

bind mbseq_top mbseq_chk #(.NCH(NCH), .PW(PW)) u_chk (.*);

// File: tb/mbseq_top_tb_top.sv
`timescale 1ns/1ps
module mbseq_top_tb_top;
  localparam int NCH = 4;
  localparam int PW  = 8;

  logic clk;
  logic rst_n;
  logic [NCH-1:0] ch_en, cfg_src_rel, cfg_dst_rel, cfg_src_nofetch, cfg_dst_nofetch, cfg_auto;
  logic [NCH*PW-1:0] cfg_ptr;
  logic [NCH-1:0] buf_done, ld_done;
  logic ld_src_nofetch, ld_dst_nofetch;
  logic [PW-1:0] ld_ptr;
  logic [NCH-1:0] xfer_en, req_reload, req_fetch, ch_done;
  logic [NCH*PW-1:0] req_ptr;
  logic [NCH-1:0] msk_buf, msk_chain, st_clr_buf, st_clr_chain;
  logic [NCH-1:0] st_buf, st_chain, irq_buf, irq_chain;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  mbseq_top #(.NCH(NCH), .PW(PW)) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  endtask

  // 0 stop, 1 reload, 2 fetch
  function automatic int model(bit srl, bit drl, bit sf, bit df, bit au, int p);
    if (au && sf && df && (srl || drl)) return 1;
    if ((!sf || !df) && p != 0) return 2;
    return 0;
  endfunction

  task automatic pulse_buf(input int c);
    buf_done[c] = 1'b1;
    step();
    buf_done[c] = 1'b0;
  endtask

  task automatic load(input int c, input bit sf, input bit df, input int p);
    ld_src_nofetch = sf;
    ld_dst_nofetch = df;
    ld_ptr = p[PW-1:0];
    ld_done[c] = 1'b1;
    step();
    ld_done[c] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int e, p;
    bit srl, drl, sf, df, au;
    rst_n = 1'b0;
    ch_en = '0; cfg_src_rel = '0; cfg_dst_rel = '0; cfg_src_nofetch = '1; cfg_dst_nofetch = '1;
    cfg_auto = '0; cfg_ptr = '0; buf_done = '0; ld_done = '0;
    ld_src_nofetch = 1'b1; ld_dst_nofetch = 1'b1; ld_ptr = '0;
    msk_buf = '0; msk_chain = '0; st_clr_buf = '0; st_clr_chain = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("reset xfer_en", int'(xfer_en), 0);
    chk("reset status R7", int'({st_buf, st_chain}), 0);
    chk("reset irq R10", int'({irq_buf, irq_chain}), 0);

    // R7: buffer end on idle channel ignored
    pulse_buf(0);
    chk("R7 idle buf_done st_buf", st_buf[0], 0);
    chk("R2 idle buf_done ch_done", ch_done[0], 0);

    // Sweep every mode-bit combination with zero and non-zero pointer on ch0
    for (int v = 0; v < 64; v++) begin
      srl = v[0]; drl = v[1]; sf = v[2]; df = v[3]; au = v[4];
      p = v[5] ? 8'hA5 : 0;
      e = model(srl, drl, sf, df, au, p);
      cfg_src_rel[0] = srl; cfg_dst_rel[0] = drl;
      cfg_src_nofetch[0] = sf; cfg_dst_nofetch[0] = df; cfg_auto[0] = au;
      cfg_ptr[0 +: PW] = p[PW-1:0];
      msk_buf[0] = v[0] ^ v[2];
      msk_chain[0] = v[1];
      ch_en[0] = 1'b1; step(); ch_en[0] = 1'b0;
      chk("R1 start xfer_en", xfer_en[0], 1);
      pulse_buf(0);
      chk("R3 reload req", req_reload[0], int'(e == 1));
      chk("R5 fetch req", req_fetch[0], int'(e == 2));
      chk("R2 stop done", ch_done[0], int'(e == 0));
      if (e == 2) chk("R5 fetch ptr", int'(req_ptr[0 +: PW]), p);
      chk("R7 st_buf set", st_buf[0], 1);
      chk("R8 st_chain", st_chain[0], int'(e == 0));
      chk("R10 irq_buf", irq_buf[0], int'(msk_buf[0]));
      chk("R10 irq_chain", irq_chain[0], int'(e == 0 && msk_chain[0]));
      if (e != 0) begin
        chk("R3 paused", xfer_en[0], 0);
        cfg_auto[0] = 1'b0;
        load(0, 1'b1, 1'b1, 0);
        chk("R3 resume", xfer_en[0], 1);
        pulse_buf(0);
        chk("R6 end done", ch_done[0], 1);
        chk("R8 end chain", st_chain[0], 1);
      end
      step();
      chk("R2 done pulse width", ch_done[0], 0);
      chk("R2 idle after done", xfer_en[0], 0);
      st_clr_buf[0] = 1'b1; st_clr_chain[0] = 1'b1;
      step();
      st_clr_buf[0] = 1'b0; st_clr_chain[0] = 1'b0;
      chk("R9 cleared", int'({st_buf[0], st_chain[0]}), 0);
    end

    // R4: auto reload repeats until auto cleared mid-buffer
    cfg_src_rel[0] = 1; cfg_dst_rel[0] = 0; cfg_src_nofetch[0] = 1; cfg_dst_nofetch[0] = 1;
    cfg_auto[0] = 1;
    ch_en[0] = 1'b1; step(); ch_en[0] = 1'b0;
    // R1: ch_en while running has no effect (no restart, no status)
    ch_en[0] = 1'b1; step(); ch_en[0] = 1'b0;
    chk("R1 en ignored running", int'({xfer_en[0], ch_done[0], st_buf[0]}), 4);
    for (int k = 0; k < 3; k++) begin
      pulse_buf(0);
      chk("R4 reload repeats", req_reload[0], 1);
      load(0, 1'b0, 1'b0, 8'h33);
      chk("R4 resumed", xfer_en[0], 1);
    end
    cfg_auto[0] = 0;
    step();
    pulse_buf(0);
    chk("R4 auto cleared terminates", ch_done[0], 1);
    chk("R4 no reload after clear", req_reload[0], 0);
    step();

    // R5/R6/R12: three-descriptor chain
    cfg_src_rel[0] = 0; cfg_src_nofetch[0] = 0; cfg_dst_nofetch[0] = 1;
    cfg_ptr[0 +: PW] = 8'h10;
    ch_en[0] = 1'b1; step(); ch_en[0] = 1'b0;
    load(0, 1'b1, 1'b1, 8'h77);
    chk("R12 stray ld_done ignored", int'(req_ptr[0 +: PW]), 8'h10);
    pulse_buf(0);
    chk("R5 first fetch", req_fetch[0], 1);
    chk("R5 first ptr", int'(req_ptr[0 +: PW]), 8'h10);
    load(0, 1'b1, 1'b0, 8'h20);
    chk("R5 ptr loaded", int'(req_ptr[0 +: PW]), 8'h20);
    pulse_buf(0);
    chk("R5 second fetch", req_fetch[0], 1);
    load(0, 1'b1, 1'b1, 0);
    pulse_buf(0);
    chk("R6 null terminates", ch_done[0], 1);
    chk("R6 no fetch at end", req_fetch[0], 0);
    step();
    st_clr_buf[0] = 1; st_clr_chain[0] = 1; step(); st_clr_buf[0] = 0; st_clr_chain[0] = 0;

    // R9: set and clear in the same cycle
    cfg_src_nofetch[0] = 1; cfg_dst_nofetch[0] = 1;
    ch_en[0] = 1'b1; step(); ch_en[0] = 1'b0;
    st_clr_buf[0] = 1'b1; st_clr_chain[0] = 1'b1;
    pulse_buf(0);
    st_clr_buf[0] = 1'b0; st_clr_chain[0] = 1'b0;
    chk("R9 set wins buf", st_buf[0], 1);
    chk("R9 set wins chain", st_chain[0], 1);
    step();
    chk("R9 sticky", st_buf[0], 1);
    st_clr_buf[0] = 1; st_clr_chain[0] = 1; step(); st_clr_buf[0] = 0; st_clr_chain[0] = 0;

    // R11: channel 1 activity leaves channel 0 untouched
    cfg_dst_rel[1] = 1; cfg_src_nofetch[1] = 1; cfg_dst_nofetch[1] = 1; cfg_auto[1] = 1;
    msk_buf[1] = 1;
    ch_en[1] = 1'b1; step(); ch_en[1] = 1'b0;
    pulse_buf(1);
    chk("R11 ch1 reload", req_reload[1], 1);
    chk("R11 ch0 quiet", int'({xfer_en[0], req_reload[0], st_buf[0], irq_buf[0]}), 0);
    chk("R10 ch1 irq", irq_buf[1], 1);
    cfg_auto[1] = 0;
    load(1, 1'b1, 1'b1, 0);
    pulse_buf(1);
    chk("R11 ch1 done", ch_done[1], 1);
    chk("R11 ch0 no done", ch_done[0], 0);
    step();
    report();
  end
endmodule